// File: doc/BRIEF.md
# Multicast Cell Buffer Manager

This block owns a pool of fixed-size cell slots kept in an on-chip memory. Each slot is a record of sixteen 32-bit words. Word 0 is the slot's reference count. Word 1 holds the cell header. Words 2 to 13 hold the 48-byte payload. A later word carries a 2-bit origin code and a 16-bit reassembly-context index. The origin code reads 00 for receive port A, 01 for receive port B and 11 for the CPU transmit path. Unused slots are chained in a linked free list. A slot's link is kept only while the slot sits on that list.

A client asks for a slot and receives its pointer in the same cycle. It then fills the slot's words through the write port. Finally it enqueues the pointer with a destination mask, which appends it to every selected transmit queue. The reference count is set to the number of destinations. Each time a queue sends the cell, the count drops by one, and the send that reaches zero returns the slot to the head of the free list. Several queues may ask to send in one cycle. A fixed-priority arbiter picks one per cycle, so the count is reduced exactly once per send.

Top module: `mcast_cell_pool`

## Requirements
- R1: After reset all 64 slots are free, linked in ascending order, so successive grants return pointers 0, 1, 2, ... 63.
- R2: `allocGrant` is high in the same cycle as `allocReq` exactly when the free list is non-empty. It is low while the list is empty, and nothing is taken from the list then.
- R3: A freed slot is pushed onto the head of the free list, so the next grant returns the most recently freed pointer.
- R4: An enqueue sets the slot's count to the number of set bits in `enqMask`. The count reads back on `rdData` as word index 0, zero-extended. Writes to word index 0 are ignored.
- R5: Each accepted send lowers the sent cell's count by one. The send that takes the count from 1 to 0 returns the slot to the free list.
- R6: Each destination queue is first-in first-out. `qNotEmpty[q]` and the q-th 6-bit field of `qHeadPtr` (bits 6q+5..6q) show its state and oldest pointer.
- R7: Among queues with `sendReq` set and a non-empty queue, the lowest index wins. `sendAck` is one-hot or zero, and `sendPtr` is the winner's head pointer. Losing queues keep their contents.
- R8: An enqueue with an all-zero mask frees the slot at once. In that cycle no send is accepted.
- R9: Words 1 to 15 written through the write port read back unchanged on the combinational read port.
- R10: When a grant and a free happen in the same cycle, the grant returns the old head, the freed slot becomes the new head, and the free count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocReq | input | 1 | Request a free slot |
| allocGrant | output | 1 | Slot granted this cycle |
| allocPtr | output | 6 | Pointer of the granted slot (free-list head) |
| wrEn | input | 1 | Cell word write strobe |
| wrPtr | input | 6 | Slot to write |
| wrWord | input | 4 | Word index within the slot |
| wrData | input | 32 | Word value |
| enqValid | input | 1 | Enqueue a slot pointer |
| enqPtr | input | 6 | Slot to enqueue |
| enqMask | input | 4 | Destination queues, one bit per queue |
| sendReq | input | 4 | Per-queue send request |
| sendAck | output | 4 | One-hot grant of the accepted send |
| sendPtr | output | 6 | Slot sent by the winning queue |
| qNotEmpty | output | 4 | Per-queue occupancy flag |
| qHeadPtr | output | 24 | Oldest pointer of each queue, 6 bits per queue |
| rdPtr | input | 6 | Slot to read |
| rdWord | input | 4 | Word index to read |
| rdData | output | 32 | Word value; index 0 gives the count |

## Verification
The bench targets several corner cases, each with a distinct failure signature. An allocation while the pool is drained would hand out a slot twice if the grant were not suppressed. A grant in the same cycle as a free would lose a slot or corrupt the chain if the link written for the freed slot were wrong, and later grants would then differ from the model's free-list order. Simultaneous send requests would double-decrement a shared cell without the one-winner rule, freeing it while other queues still hold it. A zero-mask enqueue that lands in a cycle with pending sends would need two free-list pushes at once; the bench checks that the sends are held off that cycle instead.

// File: rtl/mcast_cell_pool_pkg.sv
package mcast_cell_pool_pkg;
  parameter int unsigned SLOTS  = 64;
  parameter int unsigned QUEUES = 4;
  parameter int unsigned WORDS  = 16;
  parameter int unsigned DATA_W = 32;

  localparam int unsigned PTR_W  = $clog2(SLOTS);
  localparam int unsigned OCC_W  = $clog2(SLOTS + 1);
  localparam int unsigned CNT_W  = $clog2(QUEUES + 1);
  localparam int unsigned WIDX_W = $clog2(WORDS);
  localparam int unsigned QIDX_W = (QUEUES > 1) ? $clog2(QUEUES) : 1;

  typedef logic [PTR_W-1:0] ptr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              pushFree;   // write link of freed slot
    ptr_t              freePtr;
    ptr_t              pushLink;
    logic              setCount;   // enqueue loads reference count
    ptr_t              setPtr;
    logic [CNT_W-1:0]  setVal;
    logic              decCount;   // accepted send
    ptr_t              decPtr;
    logic [QUEUES-1:0] qPush;
    ptr_t              qPushPtr;
    logic [QUEUES-1:0] qPop;
  } strobe_t;
endpackage

// File: rtl/mcast_cell_pool_dpath.sv
module mcast_cell_pool_dpath
  import mcast_cell_pool_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  ptr_t                freeHead,
  input  ptr_t                peekPtr,
  output ptr_t                headLink,
  output logic [CNT_W-1:0]    peekCnt,
  output ptr_t                qHead [QUEUES],
  output logic [QUEUES-1:0]   qEmpty,
  input  logic                wrEn,
  input  ptr_t                wrPtr,
  input  logic [WIDX_W-1:0]   wrWord,
  input  logic [DATA_W-1:0]   wrData,
  input  ptr_t                rdPtr,
  input  logic [WIDX_W-1:0]   rdWord,
  output logic [DATA_W-1:0]   rdData
);
  ptr_t             linkMem [SLOTS];
  logic [CNT_W-1:0] counts  [SLOTS];
  logic [DATA_W-1:0] cellMem [SLOTS][WORDS];

  // Free-list links: ascending chain after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) linkMem[i] <= ptr_t'((i + 1) % SLOTS);
    end else if (st.pushFree) begin
      linkMem[st.freePtr] <= st.pushLink;
    end
  end
  assign headLink = linkMem[freeHead];

  // Reference counts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) counts[i] <= '0;
    end else begin
      if (st.setCount) counts[st.setPtr] <= st.setVal;
      if (st.decCount) counts[st.decPtr] <= counts[st.decPtr] - CNT_W'(1);
    end
  end
  assign peekCnt = counts[peekPtr];

  // R5: a send never hits a cell whose count is already zero
  assert_dec_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.decCount |-> counts[st.decPtr] != '0);

  // Cell words; word 0 is the count and is not writable (R4)
  always_ff @(posedge clk) begin
    if (wrEn && wrWord != '0) cellMem[wrPtr][wrWord] <= wrData;
  end
  assign rdData = (rdWord == '0) ? DATA_W'(counts[rdPtr]) : cellMem[rdPtr][rdWord];

  // Destination queues
  for (genvar q = 0; q < QUEUES; q++) begin : gQueue
    ptr_t             slotQ [SLOTS];
    ptr_t             rdIdx, wrIdx;
    logic [OCC_W-1:0] occ;

    always_ff @(posedge clk) begin
      if (st.qPush[q]) slotQ[wrIdx] <= st.qPushPtr;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdIdx <= '0;
        wrIdx <= '0;
        occ   <= '0;
      end else begin
        if (st.qPush[q]) wrIdx <= (wrIdx == ptr_t'(SLOTS - 1)) ? '0 : wrIdx + ptr_t'(1);
        if (st.qPop[q])  rdIdx <= (rdIdx == ptr_t'(SLOTS - 1)) ? '0 : rdIdx + ptr_t'(1);
        occ <= occ + OCC_W'(st.qPush[q]) - OCC_W'(st.qPop[q]);
      end
    end

    assign qHead[q]  = slotQ[rdIdx];
    assign qEmpty[q] = (occ == '0);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      (st.qPush[q] && !st.qPop[q]) |-> occ < OCC_W'(SLOTS));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      st.qPop[q] |-> occ != '0);
  end
endmodule

// File: rtl/mcast_cell_pool_ctrl.sv
module mcast_cell_pool_ctrl
  import mcast_cell_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReq,
  output logic              allocGrant,
  output ptr_t              allocPtr,
  input  logic              enqValid,
  input  ptr_t              enqPtr,
  input  logic [QUEUES-1:0] enqMask,
  input  logic [QUEUES-1:0] sendReq,
  output logic [QUEUES-1:0] sendAck,
  output ptr_t              sendPtr,
  input  ptr_t              headLink,
  input  logic [CNT_W-1:0]  peekCnt,
  input  ptr_t              qHead [QUEUES],
  input  logic [QUEUES-1:0] qEmpty,
  output ptr_t              freeHead,
  output ptr_t              peekPtr,
  output strobe_t           st
);
  logic [OCC_W-1:0]  freeCnt;
  logic              enqFree, anyWin, sendFree, freeing;
  logic [QUEUES-1:0] eligible;
  logic [QIDX_W-1:0] winIdx;
  ptr_t              winPtr, freePtr;

  assign allocGrant = allocReq && (freeCnt != '0);
  assign allocPtr   = freeHead;

  // Zero-mask enqueue frees at once and holds off sends (R8)
  assign enqFree  = enqValid && (enqMask == '0);
  assign eligible = sendReq & ~qEmpty & {QUEUES{!enqFree}};
  assign anyWin   = |eligible;
  assign sendAck  = eligible & (~eligible + QUEUES'(1));

  always_comb begin
    winIdx = '0;
    for (int i = QUEUES - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = QIDX_W'(i);
    end
  end

  assign winPtr   = qHead[winIdx];
  assign sendPtr  = winPtr;
  assign peekPtr  = winPtr;
  assign sendFree = anyWin && (peekCnt == CNT_W'(1));
  assign freeing  = enqFree || sendFree;
  assign freePtr  = enqFree ? enqPtr : winPtr;

  always_comb begin
    st          = '0;
    st.pushFree = freeing;
    st.freePtr  = freePtr;
    st.pushLink = allocGrant ? headLink : freeHead;
    st.setCount = enqValid;
    st.setPtr   = enqPtr;
    st.setVal   = CNT_W'($countones(enqMask));
    st.decCount = anyWin;
    st.decPtr   = winPtr;
    st.qPush    = enqValid ? enqMask : '0;
    st.qPushPtr = enqPtr;
    st.qPop     = sendAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeHead <= '0;
      freeCnt  <= OCC_W'(SLOTS);
    end else begin
      if (freeing)         freeHead <= freePtr;
      else if (allocGrant) freeHead <= headLink;
      freeCnt <= freeCnt + OCC_W'(freeing) - OCC_W'(allocGrant);
    end
  end

  assert_free_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt <= OCC_W'(SLOTS));
  assert_alloc_drain_R2: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant && !freeing) |=> freeCnt == $past(freeCnt) - OCC_W'(1));
  assert_swap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant && freeing) |=> freeCnt == $past(freeCnt));
  assert_freed_at_head_R3: assert property (@(posedge clk) disable iff (!rstN)
    freeing |=> allocPtr == $past(freePtr));
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sendAck));
  assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sendAck & ~sendReq) == '0);
  assert_enq_free_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    enqFree |-> sendAck == '0);
endmodule

// File: rtl/mcast_cell_pool.sv
module mcast_cell_pool
  import mcast_cell_pool_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocReq,
  output logic                      allocGrant,
  output logic [PTR_W-1:0]          allocPtr,
  input  logic                      wrEn,
  input  logic [PTR_W-1:0]          wrPtr,
  input  logic [WIDX_W-1:0]         wrWord,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      enqValid,
  input  logic [PTR_W-1:0]          enqPtr,
  input  logic [QUEUES-1:0]         enqMask,
  input  logic [QUEUES-1:0]         sendReq,
  output logic [QUEUES-1:0]         sendAck,
  output logic [PTR_W-1:0]          sendPtr,
  output logic [QUEUES-1:0]         qNotEmpty,
  output logic [QUEUES*PTR_W-1:0]   qHeadPtr,
  input  logic [PTR_W-1:0]          rdPtr,
  input  logic [WIDX_W-1:0]         rdWord,
  output logic [DATA_W-1:0]         rdData
);
  strobe_t           st;
  ptr_t              freeHead, peekPtr, headLink;
  logic [CNT_W-1:0]  peekCnt;
  ptr_t              qHead [QUEUES];
  logic [QUEUES-1:0] qEmpty;

  mcast_cell_pool_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocPtr(allocPtr),
    .enqValid(enqValid), .enqPtr(enqPtr), .enqMask(enqMask),
    .sendReq(sendReq), .sendAck(sendAck), .sendPtr(sendPtr),
    .headLink(headLink), .peekCnt(peekCnt), .qHead(qHead), .qEmpty(qEmpty),
    .freeHead(freeHead), .peekPtr(peekPtr), .st(st)
  );

  mcast_cell_pool_dpath uDpath (
    .clk(clk), .rstN(rstN), .st(st),
    .freeHead(freeHead), .peekPtr(peekPtr),
    .headLink(headLink), .peekCnt(peekCnt),
    .qHead(qHead), .qEmpty(qEmpty),
    .wrEn(wrEn), .wrPtr(wrPtr), .wrWord(wrWord), .wrData(wrData),
    .rdPtr(rdPtr), .rdWord(rdWord), .rdData(rdData)
  );

  assign qNotEmpty = ~qEmpty;
  for (genvar q = 0; q < QUEUES; q++) begin : gHead
    assign qHeadPtr[q*PTR_W +: PTR_W] = qHead[q];
  end
endmodule

// File: tb/mcast_cell_pool_test.sv
`timescale 1ns/1ps
module mcast_cell_pool_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocReq = 0, wrEn = 0, enqValid = 0;
  logic        allocGrant;
  logic [5:0]  allocPtr, wrPtr = 0, enqPtr = 0, sendPtr, rdPtr = 0;
  logic [3:0]  wrWord = 0, rdWord = 0, enqMask = 0, sendReq = 0, sendAck, qNotEmpty;
  logic [31:0] wrData = 0, rdData;
  logic [23:0] qHeadPtr;

  always #2.5 clk = ~clk;

  mcast_cell_pool uut (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocGrant(allocGrant), .allocPtr(allocPtr),
    .wrEn(wrEn), .wrPtr(wrPtr), .wrWord(wrWord), .wrData(wrData),
    .enqValid(enqValid), .enqPtr(enqPtr), .enqMask(enqMask),
    .sendReq(sendReq), .sendAck(sendAck), .sendPtr(sendPtr),
    .qNotEmpty(qNotEmpty), .qHeadPtr(qHeadPtr),
    .rdPtr(rdPtr), .rdWord(rdWord), .rdData(rdData)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;
  int freeQ[$];
  int owned[$];
  int qm[4][$];
  int cnt[64];
  logic [31:0] memM[64][16];
  bit written[64][16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] lowestBit(input logic [3:0] v);
    return v & (~v + 4'd1);
  endfunction

  // One clock cycle of stimulus with model prediction and checks
  task automatic step(input bit aReq, input bit eV, input int eP, input logic [3:0] eM,
                      input logic [3:0] sReq, input bit wE = 0, input int wP = 0,
                      input int wW = 0, input logic [31:0] wD = 0);
    bit expG, eFree;
    logic [3:0] elig, expAck;
    int w;
    @(negedge clk);
    allocReq = aReq; enqValid = eV; enqPtr = 6'(eP); enqMask = eM; sendReq = sReq;
    wrEn = wE; wrPtr = 6'(wP); wrWord = 4'(wW); wrData = wD;
    #1;
    for (int q = 0; q < 4; q++) begin
      chk(qNotEmpty[q] == (qm[q].size() > 0), "R6", "qNotEmpty", qNotEmpty[q], qm[q].size() > 0);
      if (qm[q].size() > 0)
        chk(qHeadPtr[q*6 +: 6] == 6'(qm[q][0]), "R6", "queue head", qHeadPtr[q*6 +: 6], qm[q][0]);
    end
    expG  = aReq && freeQ.size() > 0;
    eFree = eV && eM == 4'd0;
    elig = '0;
    for (int q = 0; q < 4; q++) if (sReq[q] && qm[q].size() > 0 && !eFree) elig[q] = 1'b1;
    expAck = lowestBit(elig);
    chk(allocGrant == expG, "R2", "allocGrant", allocGrant, expG);
    if (expG) chk(allocPtr == 6'(freeQ[0]), "R3", "allocPtr", allocPtr, freeQ[0]);
    chk(sendAck == expAck, eFree ? "R8" : "R7", "sendAck", sendAck, expAck);
    w = -1;
    for (int q = 3; q >= 0; q--) if (expAck[q]) w = q;
    if (w >= 0) chk(sendPtr == 6'(qm[w][0]), "R7", "sendPtr", sendPtr, qm[w][0]);
    // model update
    if (expG) begin
      int g;
      g = freeQ.pop_front();
      owned.push_back(g);
    end
    if (eV) begin
      cnt[eP] = $countones(eM);
      for (int q = 0; q < 4; q++) if (eM[q]) qm[q].push_back(eP);
      if (eFree) freeQ.push_front(eP);
    end
    if (w >= 0) begin
      int p;
      p = qm[w].pop_front();
      cnt[p]--;
      if (cnt[p] == 0) freeQ.push_front(p);
    end
    if (wE && wW != 0) begin
      memM[wP][wW] = wD;
      written[wP][wW] = 1'b1;
    end
    @(posedge clk);
  endtask

  task automatic peek(input int p, input int wd, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    allocReq = 0; enqValid = 0; sendReq = 0; wrEn = 0; enqMask = 0;
    rdPtr = 6'(p); rdWord = 4'(wd);
    #1;
    exp = (wd == 0) ? 32'(cnt[p]) : memM[p][wd];
    chk(rdData == exp, tag, "rdData", rdData, exp);
  endtask

  task automatic takeOwned(input int idx, output int p);
    p = owned[idx];
    owned.delete(idx);
  endtask

  initial begin
    int p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      freeQ.push_back(i);
      cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // reset state
    chk(allocPtr == 6'd0, "R1", "reset head", allocPtr, 0);
    chk(qNotEmpty == 4'd0, "R6", "reset queues", qNotEmpty, 0);
    chk(allocGrant == 1'b0, "R2", "grant without req", allocGrant, 0);

    // R1: drain the pool in ascending order, then R2 stall
    for (int i = 0; i < 64; i++) step(1, 0, 0, 4'd0, 4'd0);
    step(1, 0, 0, 4'd0, 4'd0);

    // R9 / R4: word storage and protected count word
    step(0, 0, 0, 4'd0, 4'd0, 1, 5, 1, 32'hCAFE_0105);
    step(0, 0, 0, 4'd0, 4'd0, 1, 5, 15, 32'h0003_1234);
    step(0, 0, 0, 4'd0, 4'd0, 1, 5, 0, 32'hFFFF_FFFF);
    peek(5, 1, "R9");
    peek(5, 15, "R9");
    peek(5, 0, "R4");

    // R4: count from mask
    owned.delete(owned.find_first_index(x) with (x == 5)[0]);
    step(0, 1, 5, 4'b1111, 4'd0);
    peek(5, 0, "R4");
    owned.delete(owned.find_first_index(x) with (x == 6)[0]);
    step(0, 1, 6, 4'b0101, 4'd0);
    // R8: zero mask frees and blocks pending sends
    owned.delete(owned.find_first_index(x) with (x == 7)[0]);
    step(0, 1, 7, 4'b0000, 4'b1111);
    step(1, 0, 0, 4'd0, 4'd0);              // R3: gets slot 7 back
    // R7: priority among all four queues, R5 count walk
    for (int i = 0; i < 6; i++) step(0, 0, 0, 4'd0, 4'b1111);
    peek(5, 0, "R5");
    peek(6, 0, "R5");
    // R10: free and grant in one cycle
    owned.delete(owned.find_first_index(x) with (x == 8)[0]);
    step(0, 1, 8, 4'b1000, 4'd0);
    step(1, 0, 0, 4'd0, 4'b1000);
    step(1, 0, 0, 4'd0, 4'd0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit aR, eV, wE;
      int eP, wP, wW;
      logic [3:0] m, s;
      aR = (owned.size() < 24) && ($urandom % 2 == 0);
      eV = (owned.size() > 0) && ($urandom % 3 == 0);
      eP = 0;
      if (eV) takeOwned($urandom % owned.size(), eP);
      m = 4'($urandom % 16);
      s = 4'($urandom % 16);
      wE = (owned.size() > 0) && ($urandom % 2 == 0);
      wP = wE ? owned[$urandom % owned.size()] : 0;
      wW = $urandom % 16;
      step(aR, eV, eP, m, s, wE, wP, wW, $urandom);
      if (i % 8 == 0) begin
        p = $urandom % 64;
        peek(p, 0, "R5");
        wW = 1 + $urandom % 15;
        if (written[p][wW]) peek(p, wW, "R9");
      end
    end
    // drain queues
    for (int i = 0; i < 300; i++) step(0, 0, 0, 4'd0, 4'b1111);
    step(0, 0, 0, 4'd0, 4'd0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule